// File: doc/BRIEF.md
# Privileged Vector Length Control Register

This block is a single 64-bit system control register that holds the vector length requested by the most privileged software layer. It decodes one system-register access per cycle: five encoding fields, a read/write flag, the current privilege level (0 to 3) and a trap-enable bit. Depending on those inputs it performs the read or the write, flags the access as an undefined instruction, or asks for a trap to level 3 with a fixed syndrome class. Encodings that do not select this register are left to other logic and have no effect here.

Only a 4-bit length code is stored. The requested length in bits is (code+1)×128. A direct read returns the code exactly as it was written. The vector hardware instead sees an effective code, which is the stored code rounded down to the nearest length that the core supports. The supported lengths are set by a parameter bitmask in which bit i stands for (i+1)×128 bits. The effective code and its length in bits are continuous outputs, and they follow a write on the next cycle without any synchronization step.

Top module: `vlen_ctl_reg`

## Requirements
- R1: An access is decoded only when its encoding is op0=2'b11, op1=3'b110, CRn=4'b0001, CRm=4'b0010, op2=3'b000. Any other encoding raises no flag, returns no data and leaves the stored code unchanged.
- R2: A decoded access at privilege level 0, 1 or 2 raises `undef_o` one cycle later and leaves the stored code unchanged, for both reads and writes.
- R3: A decoded access at level 3 with `trap_en`=0 raises `trap_o` one cycle later with `trap_class`=6'h19. It neither reads nor writes the register.
- R4: A read returns the stored code in `rd_data[3:0]`, and bits [63:4] of `rd_data` are always zero.
- R5: A decoded write at level 3 with `trap_en`=1 stores `acc_wdata[3:0]`, ignores bits [63:4], and raises no flag.
- R6: `eff_len` is the largest i with `IMPL_MASK[i]`=1 and i ≤ the stored code. `IMPL_MASK[0]` is always 1.
- R7: `eff_bits` equals (`eff_len`+1)×128.
- R8: `eff_len` and `eff_bits` show the newly written code in the cycle right after the write edge.
- R9: Every response (`rd_valid`, `undef_o`, `trap_o`) is registered, appears for exactly one cycle after the access, and at most one of them is high at a time.
- R10: While reset is active, and until the first access after it, `rd_valid`, `undef_o` and `trap_o` are low. The stored code takes an arbitrary fixed value that software must not rely on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | A system-register access is presented this cycle |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| trap_en | input | 1 | 0 makes a level-3 access trap |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | 64 | Read data, zero when not valid |
| undef_o | output | 1 | Undefined-instruction indication |
| trap_o | output | 1 | Trap-to-level-3 request |
| trap_class | output | 6 | Syndrome class of the trap, zero otherwise |
| eff_len | output | 4 | Effective length code after rounding down |
| eff_bits | output | 12 | Effective vector length in bits |

## Verification
The hardest case to reach from the ports is a refused access that would have changed the stored code. A refused write does nothing visible at the time, so the bench first writes a known code, then tries writes of a different value at every low privilege level, with the trap enable cleared, and with each encoding bit flipped in turn. After each attempt it reads the register back at level 3 and checks the effective outputs. The rounding is swept over all sixteen codes against a sparse mask, so codes that fall into a gap and codes that land exactly on a supported length are both covered.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  localparam int LEN_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  localparam sysreg_enc_t VLC_ENC = '{op0: 2'b11, op1: 3'b110, crn: 4'b0001,
                                      crm: 4'b0010, op2: 3'b000};

  localparam logic [5:0] VLC_TRAP_CLASS = 6'h19;
  localparam logic [1:0] PRIV_TOP       = 2'd3;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_READ  = 2'd1,
    RESP_UNDEF = 2'd2,
    RESP_TRAP  = 2'd3
  } resp_kind_t;

endpackage

// File: rtl/vlc_rst_sync.sv
module vlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/vlc_access_decode.sv
module vlc_access_decode
  import vlc_pkg::*;
(
  input  logic        acc_valid,
  input  sysreg_enc_t acc_enc,
  input  logic        acc_write,
  input  logic [1:0]  priv_lvl,
  input  logic        trap_en,
  output resp_kind_t  resp_kind,
  output logic        wr_en
);

  logic enc_hit;
  logic priv_ok;

  assign enc_hit = acc_valid && (acc_enc == VLC_ENC);
  assign priv_ok = (priv_lvl == PRIV_TOP);

  always_comb begin
    resp_kind = RESP_NONE;
    wr_en     = 1'b0;
    if (enc_hit) begin
      if (!priv_ok) begin
        resp_kind = RESP_UNDEF;
      end else if (!trap_en) begin
        resp_kind = RESP_TRAP;
      end else if (acc_write) begin
        wr_en = 1'b1;
      end else begin
        resp_kind = RESP_READ;
      end
    end
  end

endmodule

// File: rtl/vlc_len_store.sv
module vlc_len_store #(
  parameter int               LEN_W   = 4,
  parameter logic [LEN_W-1:0] RST_LEN = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LEN_W-1:0] wr_len,
  output logic [LEN_W-1:0] len_q
);

  logic [LEN_W-1:0] len_d;

  always_comb begin
    len_d = len_q;
    if (wr_en) begin
      len_d = wr_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= RST_LEN;
    end else if (wr_en) begin
      len_q <= len_d;
    end
  end

endmodule

// File: rtl/vlc_len_round.sv
module vlc_len_round #(
  parameter int                   LEN_W  = 4,
  parameter int                   NUM    = 1 << LEN_W,
  parameter logic [NUM-1:0]       MASK   = '1,
  parameter int                   BITS_W = LEN_W + 8
) (
  input  logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  eff_len,
  output logic [BITS_W-1:0] eff_bits
);

  localparam int GRAN_SHIFT = 7;

  logic [NUM-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_cand
      assign cand[g] = MASK[g] && (req_len >= LEN_W'(g));
    end
  endgenerate

  always_comb begin
    eff_len = '0;
    for (int i = 0; i < NUM; i++) begin
      if (cand[i]) begin
        eff_len = LEN_W'(i);
      end
    end
  end

  assign eff_bits = (BITS_W'(eff_len) + BITS_W'(1)) << GRAN_SHIFT;

endmodule

// File: rtl/vlen_ctl_reg.sv
module vlen_ctl_reg
  import vlc_pkg::*;
#(
  parameter int                       L_W       = LEN_W,
  parameter int                       D_W       = DATA_W,
  parameter logic [(1 << L_W)-1:0]    IMPL_MASK = 16'h8A8B,
  parameter logic [L_W-1:0]           RST_LEN   = 4'hA
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic [1:0]     acc_op0,
  input  logic [2:0]     acc_op1,
  input  logic [3:0]     acc_crn,
  input  logic [3:0]     acc_crm,
  input  logic [2:0]     acc_op2,
  input  logic           acc_write,
  input  logic [D_W-1:0] acc_wdata,
  input  logic [1:0]     priv_lvl,
  input  logic           trap_en,
  output logic           rd_valid,
  output logic [D_W-1:0] rd_data,
  output logic           undef_o,
  output logic           trap_o,
  output logic [5:0]     trap_class,
  output logic [L_W-1:0] eff_len,
  output logic [L_W+7:0] eff_bits
);

  localparam int NUM    = 1 << L_W;
  localparam int BITS_W = L_W + 8;

  logic         rst_sn;
  sysreg_enc_t  acc_enc;
  resp_kind_t   resp_d;
  resp_kind_t   resp_q;
  logic         wr_en;
  logic [L_W-1:0] len_q;
  logic [D_W-1:0] rdata_d;
  logic [D_W-1:0] rdata_q;
  logic           rdata_en;

  vlc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign acc_enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn,
                     crm: acc_crm, op2: acc_op2};

  vlc_access_decode u_decode (
    .acc_valid (acc_valid),
    .acc_enc   (acc_enc),
    .acc_write (acc_write),
    .priv_lvl  (priv_lvl),
    .trap_en   (trap_en),
    .resp_kind (resp_d),
    .wr_en     (wr_en)
  );

  vlc_len_store #(.LEN_W(L_W), .RST_LEN(RST_LEN)) u_store (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr_en  (wr_en),
    .wr_len (acc_wdata[L_W-1:0]),
    .len_q  (len_q)
  );

  vlc_len_round #(.LEN_W(L_W), .NUM(NUM), .MASK(IMPL_MASK), .BITS_W(BITS_W)) u_round (
    .req_len  (len_q),
    .eff_len  (eff_len),
    .eff_bits (eff_bits)
  );

  always_comb begin
    rdata_en = (resp_d == RESP_READ);
    rdata_d  = '0;
    rdata_d[L_W-1:0] = len_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      resp_q <= RESP_NONE;
    end else begin
      resp_q <= resp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rd_valid   = (resp_q == RESP_READ);
  assign undef_o    = (resp_q == RESP_UNDEF);
  assign trap_o     = (resp_q == RESP_TRAP);
  assign rd_data    = rd_valid ? rdata_q : '0;
  assign trap_class = trap_o ? VLC_TRAP_CLASS : 6'h00;

endmodule

// File: rtl/vlen_ctl_reg_chk.sv
module vlen_ctl_reg_chk #(
  parameter logic [15:0] MASK = 16'h8A8B
) (
  input logic        clk,
  input logic        rst_sn,
  input logic        acc_valid,
  input logic [1:0]  acc_op0,
  input logic [2:0]  acc_op1,
  input logic [3:0]  acc_crn,
  input logic [3:0]  acc_crm,
  input logic [2:0]  acc_op2,
  input logic        acc_write,
  input logic [63:0] acc_wdata,
  input logic [1:0]  priv_lvl,
  input logic        trap_en,
  input logic        rd_valid,
  input logic [63:0] rd_data,
  input logic        undef_o,
  input logic        trap_o,
  input logic [5:0]  trap_class,
  input logic [3:0]  eff_len,
  input logic [3:0]  len_q
);

  logic hit;
  assign hit = acc_valid && acc_op0 == 2'b11 && acc_op1 == 3'b110 &&
               acc_crn == 4'b0001 && acc_crm == 4'b0010 && acc_op2 == 3'b000;

  p_miss_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_valid && !hit) |=> (!rd_valid && !undef_o && !trap_o && len_q == $past(len_q)));

  p_undef_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (hit && priv_lvl != 2'd3) |=> undef_o);

  p_keep_low_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_valid && priv_lvl != 2'd3) |=> (len_q == $past(len_q)));

  p_trap_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (hit && priv_lvl == 2'd3 && !trap_en) |=> (trap_o && trap_class == 6'h19 && !rd_valid));

  p_trap_keep_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_valid && priv_lvl == 2'd3 && !trap_en) |=> (len_q == $past(len_q)));

  p_rd_upper_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_valid |-> (rd_data[63:4] == 60'd0));

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (hit && priv_lvl == 2'd3 && trap_en && acc_write) |=> (len_q == $past(acc_wdata[3:0])));

  p_round_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (eff_len <= len_q) && MASK[eff_len]);

  p_one_resp_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({rd_valid, undef_o, trap_o}));

endmodule

bind vlen_ctl_reg vlen_ctl_reg_chk #(.MASK(IMPL_MASK)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .acc_valid  (acc_valid),
  .acc_op0    (acc_op0),
  .acc_op1    (acc_op1),
  .acc_crn    (acc_crn),
  .acc_crm    (acc_crm),
  .acc_op2    (acc_op2),
  .acc_write  (acc_write),
  .acc_wdata  (acc_wdata),
  .priv_lvl   (priv_lvl),
  .trap_en    (trap_en),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .undef_o    (undef_o),
  .trap_o     (trap_o),
  .trap_class (trap_class),
  .eff_len    (eff_len),
  .len_q      (len_q)
);

// File: tb/vlen_ctl_reg_bench.sv
`timescale 1ns/1ps
module vlen_ctl_reg_bench;

  localparam logic [15:0] MASK    = 16'h8A8B;
  localparam logic [15:0] GOOD_ENC = {2'b11, 3'b110, 4'b0001, 4'b0010, 3'b000};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [15:0] enc;
  logic        acc_write;
  logic [63:0] acc_wdata;
  logic [1:0]  priv_lvl;
  logic        trap_en;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        undef_o;
  logic        trap_o;
  logic [5:0]  trap_class;
  logic [3:0]  eff_len;
  logic [11:0] eff_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vlen_ctl_reg #(.IMPL_MASK(MASK)) u_vlen_ctl_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_op0    (enc[15:14]),
    .acc_op1    (enc[13:11]),
    .acc_crn    (enc[10:7]),
    .acc_crm    (enc[6:3]),
    .acc_op2    (enc[2:0]),
    .acc_write  (acc_write),
    .acc_wdata  (acc_wdata),
    .priv_lvl   (priv_lvl),
    .trap_en    (trap_en),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .undef_o    (undef_o),
    .trap_o     (trap_o),
    .trap_class (trap_class),
    .eff_len    (eff_len),
    .eff_bits   (eff_bits)
  );

  function automatic logic [3:0] expect_eff(input logic [3:0] code);
    logic [3:0] r = 4'd0;
    for (int k = 0; k <= 15; k++) begin
      if (k <= int'(code) && MASK[k]) r = 4'(k);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] pl, input logic te, input logic wr,
                        input logic [63:0] wd, input logic [15:0] flip);
    @(negedge clk);
    acc_valid = 1'b1;
    enc       = GOOD_ENC ^ flip;
    priv_lvl  = pl;
    trap_en   = te;
    acc_write = wr;
    acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
  endtask

  task automatic check_flags(input bit rv, input bit ud, input bit tp, input string req);
    check({rd_valid, undef_o, trap_o} == {rv, ud, tp}, req,
          {61'd0, rd_valid, undef_o, trap_o}, {61'd0, rv, ud, tp});
  endtask

  task automatic read_back(input logic [3:0] exp, input string req);
    access(2'd3, 1'b1, 1'b0, 64'd0, 16'd0);
    check(rd_valid && rd_data == {60'd0, exp}, req, rd_data, {60'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; enc = GOOD_ENC; acc_write = 1'b0;
    acc_wdata = '0; priv_lvl = 2'd0; trap_en = 1'b0;
    repeat (3) @(negedge clk);
    // R10: no response flags during reset
    check_flags(1'b0, 1'b0, 1'b0, "R10 reset flags");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_flags(1'b0, 1'b0, 1'b0, "R10 flags after release");

    // R5 R6 R7 R8 R4: sweep every code, high bits of write data set
    for (int c = 0; c < 16; c++) begin
      logic [3:0] code = 4'(c);
      access(2'd3, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_1FF0 | {60'd0, code}, 16'd0);
      check_flags(1'b0, 1'b0, 1'b0, "R5 write raises no flag");
      check(eff_len == expect_eff(code), "R6 R8 rounded length", {60'd0, eff_len},
            {60'd0, expect_eff(code)});
      check(eff_bits == 12'((int'(expect_eff(code)) + 1) * 128), "R7 length in bits",
            {52'd0, eff_bits}, 64'((int'(expect_eff(code)) + 1) * 128));
      read_back(code, "R4 R5 read returns stored code");
      @(negedge clk);
      check_flags(1'b0, 1'b0, 1'b0, "R9 response lasts one cycle");
    end

    access(2'd3, 1'b1, 1'b1, 64'h9, 16'd0);

    // R2: low privilege levels refused, code unchanged
    for (int p = 0; p < 3; p++) begin
      for (int w = 0; w < 2; w++) begin
        access(2'(p), 1'b1, 1'(w), 64'h2, 16'd0);
        check_flags(1'b0, 1'b1, 1'b0, "R2 undefined at low level");
        check(eff_len == expect_eff(4'h9), "R2 effective length kept",
              {60'd0, eff_len}, {60'd0, expect_eff(4'h9)});
        read_back(4'h9, "R2 stored code kept");
      end
    end

    // R3: trap when enable is clear
    for (int w = 0; w < 2; w++) begin
      access(2'd3, 1'b0, 1'(w), 64'h2, 16'd0);
      check_flags(1'b0, 1'b0, 1'b1, "R3 trap raised");
      check(trap_class == 6'h19, "R3 syndrome class", {58'd0, trap_class}, 64'h19);
      check(rd_data == 64'd0, "R3 no read data", rd_data, 64'd0);
      read_back(4'h9, "R3 stored code kept");
    end

    // R1: each single encoding bit flipped is ignored
    for (int b = 0; b < 16; b++) begin
      access(2'd3, 1'b1, 1'b1, 64'h3, 16'(1) << b);
      check_flags(1'b0, 1'b0, 1'b0, "R1 foreign encoding write ignored");
      access(2'd0, 1'b0, 1'b0, 64'h3, 16'(1) << b);
      check_flags(1'b0, 1'b0, 1'b0, "R1 foreign encoding at low level ignored");
    end
    read_back(4'h9, "R1 stored code kept");
    check(eff_len == expect_eff(4'h9), "R1 effective length kept",
          {60'd0, eff_len}, {60'd0, expect_eff(4'h9)});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule